// File: doc/BRIEF.md
# Two-Generation Write-Once Symbol Codec

This block turns a 2-bit data symbol into a 3-bit codeword for a storage medium whose erased cells read as 1 and whose programming can only clear bits. Each symbol can be written twice between erases. The first write uses one codebook and the second write uses another. Every move from a first-write codeword to a second-write codeword only clears bits. The block also decodes the codeword that is currently stored. It reports that codeword's data value and how many writes it has taken. It raises a flag when the requested update is not allowed.

The caller presents the stored codeword and the new data value, then pulses the strobe. One clock later the registered outputs hold four things: the codeword to program, the decoded value of the word that was stored, that word's generation, and the error flag. The outputs keep these values until the next strobe. Generation is coded as 0 for erased, 1 for one write and 2 for two writes. The block does not access the array, compute ECC or split wider data into symbols.

Top module: `wom2_codec`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), new_cw is 3'b111, rd_data is 2'b00, rd_gen is 2'd0 and upd_err is 0.
- R2: When the stored word is 3'b111 (erased), a strobe yields the first-write codeword. Data 00 gives 111, 01 gives 110, 10 gives 101 and 11 gives 011. upd_err stays 0.
- R3: When the stored word holds exactly two ones and the data differs from its decoded value, the second-write codeword is produced with upd_err 0. Data 00 gives 000, 01 gives 001, 10 gives 010 and 11 gives 100.
- R4: A strobe whose data equals the stored word's decoded value returns the stored word unchanged, with upd_err 0, in both generation 1 and generation 2.
- R5: A strobe with a generation-2 stored word and a different data value sets upd_err to 1 and returns new_cw equal to the stored word.
- R6: rd_data is the decoded value of the stored word sampled at the strobe. Erased decodes to 00. With two ones, the position of the single zero gives the value: bit 0 gives 01, bit 1 gives 10, bit 2 gives 11. With one one, its position gives the value in the same way. 000 decodes to 00.
- R7: rd_gen is set by the number of ones in the stored word: three ones give 0, two ones give 1, one or zero ones give 2.
- R8: All outputs change only on the clock edge at which enc_strobe is high. They show that strobe's result from that edge on and hold while enc_strobe is low.
- R9: new_cw never has a 1 where the stored word sampled at the strobe had a 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| enc_strobe | input | 1 | Samples the inputs and updates the outputs at this edge |
| wr_data | input | 2 | Data symbol to be written |
| stored_cw | input | 3 | Codeword currently held in the medium |
| new_cw | output | 3 | Codeword to program (registered) |
| rd_data | output | 2 | Decoded value of the sampled stored word (registered) |
| rd_gen | output | 2 | Generation of the sampled stored word (registered) |
| upd_err | output | 1 | Update not allowed; new_cw equals the stored word (registered) |

## Verification
Decoding the stored word and encoding the requested update always happen on the same strobe edge. The sharpest case is a generation-2 word written with a different value: the decoder must report generation 2 and the old value while the encoder raises the error and returns the word unchanged. The bench provokes this by strobing stored words 001 and 000 with foreign data. It judges all four outputs from the single sample taken half a clock after that edge. It also strobes words whose value matches the data, to show that the same-value path and the overflow path do not mix in one cycle.

// File: rtl/wom2_pkg.sv
// Package: shared widths, generation encoding and the two codebooks.
// Assumes erased cells read as 1 and programming only clears bits.
package wom2_pkg;
    localparam int SYM_W  = 2;
    localparam int CODE_W = 3;
    localparam int CNT_W  = $clog2(CODE_W + 1);
    localparam logic [CODE_W-1:0] CW_BLANK = '1;

    typedef enum logic [1:0] {
        GEN_BLANK  = 2'd0,
        GEN_ONCE   = 2'd1,
        GEN_TWICE  = 2'd2
    } wom_gen_e;

    // First-write codebook: a single zero marks the value (00 keeps all ones).
    function automatic logic [CODE_W-1:0] book_first(input logic [SYM_W-1:0] v);
        case (v)
            2'b00:   book_first = 3'b111;
            2'b01:   book_first = 3'b110;
            2'b10:   book_first = 3'b101;
            default: book_first = 3'b011;
        endcase
    endfunction

    // Second-write codebook: a single one marks the value (00 clears all).
    function automatic logic [CODE_W-1:0] book_second(input logic [SYM_W-1:0] v);
        case (v)
            2'b00:   book_second = 3'b000;
            2'b01:   book_second = 3'b001;
            2'b10:   book_second = 3'b010;
            default: book_second = 3'b100;
        endcase
    endfunction
endpackage

// File: rtl/wom2_decoder.sv
// Module: wom2_decoder
// Classifies a stored codeword by its count of ones and recovers its value.
// Assumes every 3-bit pattern is a possible input; all are mapped.
module wom2_decoder
    import wom2_pkg::*;
(
    input  logic [CODE_W-1:0] cw_in,
    output wom_gen_e          gen_out,
    output logic [SYM_W-1:0]  val_out
);
    logic [CNT_W-1:0] ones;

    // Count the set bits of the codeword.
    always_comb begin
        ones = '0;
        for (int i = 0; i < CODE_W; i++) begin
            ones = ones + CNT_W'(cw_in[i]);
        end
    end

    // Map the count to a generation and the marker position to a value.
    always_comb begin
        gen_out = GEN_TWICE;
        val_out = '0;
        if (ones == CNT_W'(CODE_W)) begin
            gen_out = GEN_BLANK;
        end else if (ones == CNT_W'(CODE_W - 1)) begin
            gen_out = GEN_ONCE;
            for (int i = 0; i < CODE_W; i++) begin
                if (!cw_in[i]) val_out = SYM_W'(i + 1);
            end
        end else begin
            for (int i = 0; i < CODE_W; i++) begin
                if (cw_in[i]) val_out = SYM_W'(i + 1);
            end
        end
    end
endmodule

// File: rtl/wom2_encoder.sv
// Module: wom2_encoder
// Picks the next codeword from the stored word's generation and value.
// Rejects overflow past the second write and any 0-to-1 flip.
// Assumes gen_in/val_in come from decoding stored_in.
module wom2_encoder
    import wom2_pkg::*;
(
    input  logic [CODE_W-1:0] stored_in,
    input  wom_gen_e          gen_in,
    input  logic [SYM_W-1:0]  val_in,
    input  logic [SYM_W-1:0]  data_in,
    output logic [CODE_W-1:0] next_cw,
    output logic              reject
);
    logic [CODE_W-1:0] cand;
    logic              overflow;
    logic              raises_bit;

    // Choose the candidate word for the requested symbol.
    always_comb begin
        cand     = stored_in;
        overflow = 1'b0;
        unique case (gen_in)
            GEN_BLANK: cand = book_first(data_in);
            GEN_ONCE:  cand = (data_in == val_in) ? stored_in : book_second(data_in);
            default: begin
                if (data_in != val_in) overflow = 1'b1;
            end
        endcase
    end

    // Guard against any bit that would need to go from 0 to 1.
    always_comb begin
        raises_bit = |(cand & ~stored_in);
        reject     = overflow | raises_bit;
        next_cw    = reject ? stored_in : cand;
    end
endmodule

// File: rtl/wom2_codec.sv
// Module: wom2_codec (top)
// Registers the encode and decode results on each strobe.
// Assumes stored_cw and wr_data are stable at the strobe edge.
module wom2_codec
    import wom2_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enc_strobe,
    input  logic [1:0] wr_data,
    input  logic [2:0] stored_cw,
    output logic [2:0] new_cw,
    output logic [1:0] rd_data,
    output logic [1:0] rd_gen,
    output logic       upd_err
);
    wom_gen_e          dec_gen;
    logic [SYM_W-1:0]  dec_val;
    logic [CODE_W-1:0] enc_cw;
    logic              enc_rej;

    wom2_decoder u_dec (
        .cw_in   (stored_cw),
        .gen_out (dec_gen),
        .val_out (dec_val)
    );

    wom2_encoder u_enc (
        .stored_in (stored_cw),
        .gen_in    (dec_gen),
        .val_in    (dec_val),
        .data_in   (wr_data),
        .next_cw   (enc_cw),
        .reject    (enc_rej)
    );

    // Capture the results on a strobe; hold them otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            new_cw  <= CW_BLANK;
            rd_data <= '0;
            rd_gen  <= GEN_BLANK;
            upd_err <= 1'b0;
        end else if (enc_strobe) begin
            new_cw  <= enc_cw;
            rd_data <= dec_val;
            rd_gen  <= dec_gen;
            upd_err <= enc_rej;
        end
    end
endmodule

// File: rtl/wom2_codec_chk.sv
// Module: wom2_codec_chk
// Temporal checks on the codec ports, bound to every wom2_codec instance.
module wom2_codec_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       enc_strobe,
    input logic [1:0] wr_data,
    input logic [2:0] stored_cw,
    input logic [2:0] new_cw,
    input logic [1:0] rd_data,
    input logic [1:0] rd_gen,
    input logic       upd_err
);
    AST_NO_RAISED_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(enc_strobe)) |-> ((new_cw & ~$past(stored_cw)) == 3'b000)); // R9

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(enc_strobe)) |->
        ($stable(new_cw) && $stable(rd_data) && $stable(rd_gen) && $stable(upd_err))); // R8

    AST_ERR_KEEPS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(enc_strobe) && upd_err) |-> (new_cw == $past(stored_cw))); // R5

    AST_ERR_ONLY_GEN2: assert property (@(posedge clk) disable iff (!rst_n)
        upd_err |-> (rd_gen == 2'd2)); // R5

    AST_BLANK_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(enc_strobe) && $past(stored_cw) == 3'b111) |->
        (($countones(new_cw) >= 2) && !upd_err)); // R2

    AST_SAME_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(enc_strobe) && rd_gen != 2'd0 && rd_data == $past(wr_data)) |->
        (new_cw == $past(stored_cw) && !upd_err)); // R4
endmodule

bind wom2_codec wom2_codec_chk u_wom2_codec_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .enc_strobe (enc_strobe),
    .wr_data    (wr_data),
    .stored_cw  (stored_cw),
    .new_cw     (new_cw),
    .rd_data    (rd_data),
    .rd_gen     (rd_gen),
    .upd_err    (upd_err)
);

// File: tb/test_wom2_codec.sv
// Directed bench for wom2_codec: one task per scenario, each self-checking.
module test_wom2_codec;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enc_strobe = 1'b0;
    logic [1:0] wr_data = 2'b00;
    logic [2:0] stored_cw = 3'b111;
    logic [2:0] new_cw;
    logic [1:0] rd_data;
    logic [1:0] rd_gen;
    logic       upd_err;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    wom2_codec i_wom2_codec (
        .clk        (clk),
        .rst_n      (rst_n),
        .enc_strobe (enc_strobe),
        .wr_data    (wr_data),
        .stored_cw  (stored_cw),
        .new_cw     (new_cw),
        .rd_data    (rd_data),
        .rd_gen     (rd_gen),
        .upd_err    (upd_err)
    );

    // Compare one value and record the result.
    task automatic chk(input string req, input string what, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
        end
    endtask

    // Strobe one update at a falling edge; sample at the next falling edge.
    task automatic strobe(input logic [2:0] cw, input logic [1:0] d);
        @(negedge clk);
        stored_cw  = cw;
        wr_data    = d;
        enc_strobe = 1'b1;
        @(negedge clk);
        enc_strobe = 1'b0;
    endtask

    // Strobe and check all four outputs against the expected values.
    task automatic expect_upd(input string req, input logic [2:0] cw, input logic [1:0] d,
                              input logic [2:0] e_cw, input logic [1:0] e_dat,
                              input logic [1:0] e_gen, input logic e_err);
        strobe(cw, d);
        chk(req, "new_cw", int'(new_cw), int'(e_cw));
        chk(req, "rd_data", int'(rd_data), int'(e_dat));
        chk(req, "rd_gen", int'(rd_gen), int'(e_gen));
        chk(req, "upd_err", int'(upd_err), int'(e_err));
        chk("R9", "no raised bit", int'(new_cw & ~cw), 0);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk("R1", "new_cw", int'(new_cw), 7);
        chk("R1", "rd_data", int'(rd_data), 0);
        chk("R1", "rd_gen", int'(rd_gen), 0);
        chk("R1", "upd_err", int'(upd_err), 0);
        rst_n = 1'b1;
    endtask

    task automatic t_first_write();
        expect_upd("R2", 3'b111, 2'b01, 3'b110, 2'b00, 2'd0, 1'b0);
        expect_upd("R2", 3'b111, 2'b10, 3'b101, 2'b00, 2'd0, 1'b0);
        expect_upd("R2", 3'b111, 2'b11, 3'b011, 2'b00, 2'd0, 1'b0);
        expect_upd("R2", 3'b111, 2'b00, 3'b111, 2'b00, 2'd0, 1'b0);
    endtask

    task automatic t_second_write();
        expect_upd("R3", 3'b110, 2'b00, 3'b000, 2'b01, 2'd1, 1'b0);
        expect_upd("R3", 3'b110, 2'b10, 3'b010, 2'b01, 2'd1, 1'b0);
        expect_upd("R3", 3'b110, 2'b11, 3'b100, 2'b01, 2'd1, 1'b0);
        expect_upd("R3", 3'b011, 2'b01, 3'b001, 2'b11, 2'd1, 1'b0);
        expect_upd("R3", 3'b101, 2'b11, 3'b100, 2'b10, 2'd1, 1'b0);
    endtask

    task automatic t_same_value();
        expect_upd("R4", 3'b101, 2'b10, 3'b101, 2'b10, 2'd1, 1'b0);
        expect_upd("R4", 3'b010, 2'b10, 3'b010, 2'b10, 2'd2, 1'b0);
        expect_upd("R4", 3'b000, 2'b00, 3'b000, 2'b00, 2'd2, 1'b0);
    endtask

    task automatic t_overflow();
        expect_upd("R5", 3'b001, 2'b11, 3'b001, 2'b01, 2'd2, 1'b1);
        expect_upd("R5", 3'b000, 2'b01, 3'b000, 2'b00, 2'd2, 1'b1);
        expect_upd("R5", 3'b100, 2'b00, 3'b100, 2'b11, 2'd2, 1'b1);
        // A legal update right after a rejected one must clear the flag.
        expect_upd("R5", 3'b111, 2'b10, 3'b101, 2'b00, 2'd0, 1'b0);
    endtask

    // Walk every stored pattern; data equals each decoded value (R6, R7).
    task automatic t_decode_all();
        logic [1:0] e_dat [8];
        logic [1:0] e_gen [8];
        e_dat[0] = 2'b00; e_gen[0] = 2'd2;
        e_dat[1] = 2'b01; e_gen[1] = 2'd2;
        e_dat[2] = 2'b10; e_gen[2] = 2'd2;
        e_dat[3] = 2'b11; e_gen[3] = 2'd1;
        e_dat[4] = 2'b11; e_gen[4] = 2'd2;
        e_dat[5] = 2'b10; e_gen[5] = 2'd1;
        e_dat[6] = 2'b01; e_gen[6] = 2'd1;
        e_dat[7] = 2'b00; e_gen[7] = 2'd0;
        for (int k = 0; k < 8; k++) begin
            strobe(3'(k), e_dat[k]);
            chk("R6", "rd_data", int'(rd_data), int'(e_dat[k]));
            chk("R7", "rd_gen", int'(rd_gen), int'(e_gen[k]));
            chk("R4", "same value keeps word", int'(new_cw), k);
        end
    endtask

    // Inputs move without a strobe: outputs must hold (R8).
    task automatic t_hold();
        expect_upd("R8", 3'b111, 2'b11, 3'b011, 2'b00, 2'd0, 1'b0);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            stored_cw = 3'(k);
            wr_data   = 2'(k + 1);
            @(negedge clk);
            chk("R8", "new_cw held", int'(new_cw), 3);
            chk("R8", "rd_gen held", int'(rd_gen), 0);
            chk("R8", "upd_err held", int'(upd_err), 0);
        end
        // Latency: a strobe raised just before an edge shows its result right after it.
        @(negedge clk);
        stored_cw  = 3'b001;
        wr_data    = 2'b10;
        enc_strobe = 1'b1;
        @(posedge clk);
        #1;
        enc_strobe = 1'b0;
        chk("R8", "upd_err after edge", int'(upd_err), 1);
        chk("R8", "rd_gen after edge", int'(rd_gen), 2);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(20 * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        t_reset();
        t_first_write();
        t_second_write();
        t_same_value();
        t_overflow();
        t_decode_all();
        t_hold();
        repeat (2) @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule